// File: doc/BRIEF.md
# Prefix-Length Partitioned Lookup Table

This block is one search unit of a RAM-based IPv4 route lookup engine. It holds routes of a single prefix length only, and its storage is split into a number of equal tables. A routing engine places one such unit per prefix length and resolves the longest match outside the block.

To store or look up a prefix of length L, the unit keeps only the top L bits of the 32-bit value. The lowest k of those L bits form the table index. The remaining upper L−k bits are the remainder. The remainder is the only part kept in an entry, and the only part compared. A search reads the indexed table once and compares every slot of that table in parallel against the remainder. It reports whether a slot matched and, if one did, the table and slot numbers.

Software or a management engine chooses the slot. It installs a route by giving the full 32-bit prefix, a slot number and a valid flag. The unit works out the table number itself with the same index rule. A new search can be accepted on every clock.

Top module: `lpt_search_unit`

## Requirements
- R1: Reset clears every entry's valid flag and `res_valid`. A search made after reset misses.
- R2: The table index is bits [32−L +: k] of the address, i.e. the last k bits of its top L bits. With the defaults (L=16, k=4) these are bits [19:16].
- R3: Only the remainder bits [31 : 32−L+k] are compared; bits [31:20] with the defaults. Address bits below the top L have no effect on the result.
- R4: On a hit, `res_hit` is 1, `res_table` gives the probed table index and `res_entry` gives the matching slot.
- R5: A slot written with the valid flag at 0 never matches, even if its stored remainder equals the key.
- R6: When several valid slots of the probed table match, the lowest slot number is reported.
- R7: The search has a fixed latency of two clocks. `res_valid` is high exactly two rising edges after `srch_en` was sampled high. Searches may arrive on back-to-back cycles.
- R8: When a write and a search are sampled on the same edge, the search sees the table contents from before that write.
- R9: A write takes its table from the prefix with the same rule as R2. Prefix bits below the top L are ignored on writes.
- R10: On a miss with `res_valid` high, `res_hit` is 0 and `res_entry` is 0. `res_hit` is never high while `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Install or remove an entry |
| wr_prefix | input | 32 | Full prefix value; the table is derived from it |
| wr_entry | input | log2(ENTRIES) | Slot within the derived table |
| wr_valid | input | 1 | Valid flag stored with the slot |
| srch_en | input | 1 | Start a search |
| srch_addr | input | 32 | Destination address to look up |
| res_valid | output | 1 | Result of a search issued two clocks earlier |
| res_hit | output | 1 | A valid slot matched |
| res_table | output | k | Table that was probed |
| res_entry | output | log2(ENTRIES) | Lowest matching slot, 0 on a miss |

## Verification
Several address patterns are used to separate the effect of each field. Changing only the index bits must move the search to a different table and miss. Changing only the remainder must miss within the same table. Changing only the bits below the top L must still hit, which tells the index window apart from the leading or trailing bits. Duplicate installs and removals check lowest-slot priority and the valid gating. A write and a search on the same cycle check that the search reads the old contents. A long burst of random writes and searches in the same small tables is compared every clock against a behavioural table model.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int ADDR_W = 32;
endpackage

// File: rtl/lpt_key_split.sv
module lpt_key_split #(
  parameter int PFX_LEN = 16,
  parameter int IDX_W   = 4
) (
  input  logic [lpt_pkg::ADDR_W-1:0]   addr,
  output logic [IDX_W-1:0]             idx,
  output logic [PFX_LEN-IDX_W-1:0]     rem
);
  localparam int LOW = lpt_pkg::ADDR_W - PFX_LEN;
  // index: the trailing k bits of the top-L slice; remainder: the rest above it
  assign idx = addr[LOW +: IDX_W];
  assign rem = addr[LOW + IDX_W +: PFX_LEN - IDX_W];
endmodule

// File: rtl/lpt_entry_ram.sv
module lpt_entry_ram #(
  parameter int AW = 4,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // read-before-write: a read on the write edge returns the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lpt_match_encode.sv
module lpt_match_encode #(
  parameter int ENTRIES = 8,
  localparam int ENT_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match,
  output logic               hit,
  output logic [ENT_W-1:0]   sel
);
  always_comb begin
    hit = |match;
    sel = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) sel = ENT_W'(e);
    end
  end

  logic lower_set;
  always_comb begin
    lower_set = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (ENT_W'(e) < sel && match[e]) lower_set = 1'b1;
    end
  end

  always_comb begin
    if (hit) begin
      a_r6_lowest_sel: assert (match[sel] && !lower_set)
        else $error("encoder picked a slot that is not the lowest match");
    end else begin
      a_r10_miss_zero: assert (sel == '0)
        else $error("encoder slot not zero on miss");
    end
  end
endmodule

// File: rtl/lpt_search_unit.sv
module lpt_search_unit #(
  parameter int PFX_LEN = 16,
  parameter int IDX_W   = 4,
  parameter int ENTRIES = 8,
  localparam int ENT_W  = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [lpt_pkg::ADDR_W-1:0] wr_prefix,
  input  logic [ENT_W-1:0]           wr_entry,
  input  logic                       wr_valid,
  input  logic                       srch_en,
  input  logic [lpt_pkg::ADDR_W-1:0] srch_addr,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic [IDX_W-1:0]           res_table,
  output logic [ENT_W-1:0]           res_entry
);
  localparam int NUM_TABLES = 1 << IDX_W;
  localparam int REM_W      = PFX_LEN - IDX_W;

  // key extraction for both ports
  logic [IDX_W-1:0] w_idx, s_idx;
  logic [REM_W-1:0] w_rem, s_rem;

  lpt_key_split #(.PFX_LEN(PFX_LEN), .IDX_W(IDX_W)) u_wkey (
    .addr(wr_prefix), .idx(w_idx), .rem(w_rem));
  lpt_key_split #(.PFX_LEN(PFX_LEN), .IDX_W(IDX_W)) u_skey (
    .addr(srch_addr), .idx(s_idx), .rem(s_rem));

  // valid flags live in flops so reset can clear them
  logic [ENTRIES-1:0] valid_q [NUM_TABLES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NUM_TABLES; t++) valid_q[t] <= '0;
    end else if (wr_en) begin
      valid_q[w_idx][wr_entry] <= wr_valid;
    end
  end

  // stage 1: table read
  logic               s1_valid;
  logic [IDX_W-1:0]   s1_idx;
  logic [REM_W-1:0]   s1_rem;
  logic [ENTRIES-1:0] s1_row_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid     <= 1'b0;
      s1_idx       <= '0;
      s1_rem       <= '0;
      s1_row_valid <= '0;
    end else begin
      s1_valid     <= srch_en;
      s1_idx       <= s_idx;
      s1_rem       <= s_rem;
      s1_row_valid <= valid_q[s_idx];
    end
  end

  // one remainder RAM per slot column, all read in the same access
  logic [ENTRIES-1:0] match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic [REM_W-1:0] slot_rem;
    lpt_entry_ram #(.AW(IDX_W), .DW(REM_W)) u_ram (
      .clk  (clk),
      .we   (wr_en && (wr_entry == ENT_W'(e))),
      .waddr(w_idx),
      .wdata(w_rem),
      .raddr(s_idx),
      .rdata(slot_rem)
    );
    assign match[e] = s1_row_valid[e] && (slot_rem == s1_rem);
  end

  logic             enc_hit;
  logic [ENT_W-1:0] enc_sel;

  lpt_match_encode #(.ENTRIES(ENTRIES)) u_enc (
    .match(match), .hit(enc_hit), .sel(enc_sel));

  // stage 2: registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_table <= '0;
      res_entry <= '0;
    end else begin
      res_valid <= s1_valid;
      res_hit   <= s1_valid && enc_hit;
      res_table <= s1_idx;
      res_entry <= enc_sel;
    end
  end

  a_r7_two_cycle: assert property (@(posedge clk) disable iff (rst)
    srch_en |=> ##1 res_valid)
    else $error("result missing two clocks after search");
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !srch_en |=> ##1 !res_valid)
    else $error("result without a search");
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> !res_valid && !res_hit)
    else $error("result active after reset");
  a_r10_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid)
    else $error("hit without valid");
  a_r10_miss_entry: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> res_entry == '0)
    else $error("non-zero slot on miss");
endmodule

// File: tb/lpt_search_unit_tb.sv
module lpt_search_unit_tb;
  localparam int PERIOD  = 10;
  localparam int PFX_LEN = 16;
  localparam int IDX_W   = 4;
  localparam int ENTRIES = 8;
  localparam int ENT_W   = 3;
  localparam int NT      = 16;

  logic clk = 1'b0;
  logic rst;
  logic wr_en, wr_valid, srch_en;
  logic [31:0] wr_prefix, srch_addr;
  logic [ENT_W-1:0] wr_entry;
  logic res_valid, res_hit;
  logic [IDX_W-1:0] res_table;
  logic [ENT_W-1:0] res_entry;

  always #(PERIOD/2) clk = ~clk;

  lpt_search_unit #(.PFX_LEN(PFX_LEN), .IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_prefix(wr_prefix),
    .wr_entry(wr_entry), .wr_valid(wr_valid), .srch_en(srch_en),
    .srch_addr(srch_addr), .res_valid(res_valid), .res_hit(res_hit),
    .res_table(res_table), .res_entry(res_entry));

  int checks = 0;
  int failures = 0;

  // behavioural table model
  int unsigned m_rem [NT][ENTRIES];
  bit          m_val [NT][ENTRIES];

  // expectation for the search issued one step earlier
  bit    p_valid = 0, p_hit = 0;
  int    p_table = 0, p_entry = 0;
  string p_tag = "R1";

  function automatic logic [31:0] mk(int rem, int idx, int low);
    return {rem[11:0], idx[3:0], low[15:0]};
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit we, logic [31:0] wp, int went, bit wv,
                      bit se, logic [31:0] sa, string tag);
    bit c_hit; int c_table, c_entry, widx;
    wr_en = we; wr_prefix = wp; wr_entry = ENT_W'(went); wr_valid = wv;
    srch_en = se; srch_addr = sa;
    // expected outcome from contents before this write (R8)
    c_table = int'(sa[19:16]);
    c_hit = 0; c_entry = 0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!c_hit && m_val[c_table][e] && m_rem[c_table][e] == int'(sa[31:20])) begin
        c_hit = 1; c_entry = e;
      end
    end
    if (we) begin
      widx = int'(wp[19:16]);
      m_rem[widx][went] = int'(wp[31:20]);
      m_val[widx][went] = wv;
    end
    @(negedge clk);
    chk(p_tag, "res_valid", int'(res_valid), int'(p_valid));
    if (p_valid) begin
      chk(p_tag, "res_hit", int'(res_hit), int'(p_hit));
      chk(p_tag, "res_table", int'(res_table), p_table);
      chk(p_tag, "res_entry", int'(res_entry), p_entry);
    end else begin
      chk(p_tag, "res_hit idle", int'(res_hit), 0);
    end
    p_valid = se; p_hit = c_hit; p_table = c_table; p_entry = c_entry; p_tag = tag;
  endtask

  task automatic srch(logic [31:0] a, string tag);
    step(0, '0, 0, 0, 1, a, tag);
  endtask

  task automatic wr(logic [31:0] p, int ent, bit v, string tag);
    step(1, p, ent, v, 0, '0, tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++)
      for (int e = 0; e < ENTRIES; e++) begin m_rem[t][e] = 0; m_val[t][e] = 0; end
    rst = 1; wr_en = 0; wr_prefix = '0; wr_entry = '0; wr_valid = 0;
    srch_en = 1; srch_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1", "res_valid in reset", int'(res_valid), 0);
    srch_en = 0;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "res_valid after reset", int'(res_valid), 0);

    // R1: empty tables miss, including a zero key against zero RAM words
    srch('0, "R1");
    srch(mk(1, 2, 0), "R1");
    // R8: write and search on the same edge see the old contents
    step(1, mk(12'hABC, 5, 16'h1234), 3, 1, 1, mk(12'hABC, 5, 0), "R8");
    srch(mk(12'hABC, 5, 0), "R4");
    // R3: low address bits ignored; remainder mismatch misses
    srch(mk(12'hABC, 5, 16'hFFFF), "R3");
    srch(mk(12'hABD, 5, 0), "R3");
    // R2: same remainder, other index bits
    srch(mk(12'hABC, 6, 0), "R2");
    srch(mk(12'hABC, 4, 0), "R2");
    // R6: duplicate in a lower slot wins
    wr(mk(12'hABC, 5, 0), 1, 1, "R6");
    srch(mk(12'hABC, 5, 7), "R6");
    // R5: invalidating the lower slot falls back to slot 3, then to miss
    wr(mk(12'hABC, 5, 0), 1, 0, "R5");
    srch(mk(12'hABC, 5, 0), "R5");
    wr(mk(12'hABC, 5, 0), 3, 0, "R5");
    srch(mk(12'hABC, 5, 0), "R5");
    // R9: write prefix with junk low bits lands in table 9
    wr(mk(12'h111, 9, 16'hBEEF), 0, 1, "R9");
    srch(mk(12'h111, 9, 0), "R9");
    srch(mk(12'h111, 8, 16'hBEEF), "R9");
    // R7: back-to-back searches then an idle gap
    wr(mk(12'h222, 15, 0), 7, 1, "R7");
    srch(mk(12'h222, 15, 0), "R7");
    srch(mk(12'h111, 9, 1), "R7");
    srch(mk(12'h333, 15, 0), "R10");
    step(0, '0, 0, 0, 0, '0, "R7");
    step(0, '0, 0, 0, 0, '0, "R7");
    // random mix in a narrow key space
    for (int i = 0; i < 400; i++) begin
      int r1, r2, r3;
      r1 = $urandom_range(3, 0); r2 = $urandom_range(3, 0); r3 = $urandom_range(7, 0);
      step($urandom_range(2, 0) == 0, mk(r1, r2, $urandom_range(65535, 0)), r3,
           $urandom_range(3, 0) != 0, $urandom_range(3, 0) != 0,
           mk($urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(65535, 0)), "R7");
    end
    step(0, '0, 0, 0, 0, '0, "R7");
    step(0, '0, 0, 0, 0, '0, "R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule